// File: doc/BRIEF.md
# Table-Driven SPI Bit-Clock Generator

This block produces the serial bit clock for an SPI controller from a single reference clock. The division ratio is chosen by a 5-bit index into a fixed table whose ratios grow alternately by 1.33x and 1.5x. Because the table includes ratios of the form 3·2^k as well as 2^k, the steps between neighbouring entries are finer than powers of two alone would allow. Alongside the clock, the block emits two single-cycle strobes per bit: one where the data shifter should drive a new bit and one where it should capture.

The index either comes straight from a pin or is computed by the block. In computed mode a request carrying a reference frequency and a target bit-clock frequency is accepted over a valid/ready handshake. A sequential search then walks the table one entry per clock and reports the smallest adequate index together with a one-cycle done pulse. The result is also shown as a 32-bit control word with the index in the field at bits 18:14. Any change of the applied ratio waits for the current bit-clock period to finish, so the shifter never sees a shortened pulse.

Top module: `spi_rate_gen`

## Requirements
- R1: The ratio for index n is 3·2^((n-1)/2) for odd n and 2^(n/2+1) for even n, for n in 1..18. This gives 3, 4, 6, 8, 12 ... 768, 1024. While enabled, the clock spends floor(ratio/2) reference cycles at the active level (the inverse of `cpol`) and the rest of the period at the idle level.
- R2: While `en` is low, `sclk` equals `cpol` and both strobes stay low. Raising `en` starts a fresh period whose active phase begins after the next clock edge.
- R3: `shift_stb` is high for exactly the first cycle of each active phase. `sample_stb` is high for exactly the first cycle of each idle phase. They are never high together.
- R4: The applied index is cleaned up before use. Index 0 becomes 2. Index 1 becomes 2 unless `fast_ok` is high. Any index above 18 becomes 18.
- R5: A change of index, whether from the pin or from a new search result, takes effect only at the end of the current bit-clock period.
- R6: The search tests indices upward from 2 and returns the first n for which target·ratio(n) >= reference. The test uses unsigned arithmetic wide enough that the product never wraps.
- R7: The search limit is 16 when `lim_sel` is 0 and 18 when it is 1. Indices up to limit-1 are tested. If none passes, the limit itself is returned untested.
- R8: `done` pulses for one cycle. For a hit at index n it comes n-1 cycles after the accepting edge; when no index passes it comes limit-2 cycles after that edge.
- R9: `req_ready` is high only while no search is running. A request is taken on an edge where `req_valid` and `req_ready` are both high. A request held while busy waits, unchanged, and is taken on the first edge after `done`.
- R10: `res_idx` holds the last search result (2 after reset). `res_word` carries that index at bits 18:14 and zeros in every other bit. Both update together with `done`.
- R11: When `use_auto` is high, the generator applies `res_idx` instead of `idx_in`, subject to R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run the bit clock |
| cpol | input | 1 | Idle level of `sclk` |
| fast_ok | input | 1 | Permit index 1 (ratio 3) |
| use_auto | input | 1 | Apply the search result instead of `idx_in` |
| idx_in | input | 5 | Manually selected table index |
| lim_sel | input | 1 | Search limit: 0 gives 16, 1 gives 18 |
| req_valid | input | 1 | Search request present |
| req_ready | output | 1 | Search engine idle, request can be taken |
| ref_hz | input | 32 | Reference frequency for the search |
| tgt_hz | input | 32 | Wanted bit-clock frequency for the search |
| sclk | output | 1 | Bit clock |
| shift_stb | output | 1 | One-cycle strobe at the start of each active phase |
| sample_stb | output | 1 | One-cycle strobe at the start of each idle phase |
| res_idx | output | 5 | Last search result |
| res_word | output | 32 | Control word with `res_idx` at bits 18:14 |
| done | output | 1 | One-cycle pulse when a search result is ready |

## Verification
After `en` rises, the active phase starts one edge later, and each phase length is counted in reference cycles directly from `sclk`. The strobes are checked on the same sampled cycle in which `sclk` changes level. A search result is due n-1 edges after the accepting edge for a hit at n, or limit-2 edges when nothing passes. The bench counts edges from acceptance up to the sample where `done` shows and compares that count exactly, then checks that `done` is low on the following sample. All sampling happens on the falling edge, so every registered output is read one half-period after the edge that set it.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;
  localparam int IDX_W    = 5;
  localparam int RATIO_W  = 11;
  localparam int IDX_TOP  = 18;
  localparam int IDX_SAFE = 2;
  localparam int WORD_W   = 32;
  localparam int FIELD_LSB = 14;

  // ratio for a table index: odd -> 3*2^k, even -> 2^(n/2+1); 0 -> 0
  function automatic logic [RATIO_W-1:0] ratio_of(input logic [IDX_W-1:0] n);
    logic [RATIO_W-1:0] r;
    if (n == '0)
      r = '0;
    else if (n[0])
      r = RATIO_W'(3) << ((n - 1) >> 1);
    else
      r = RATIO_W'(1) << ((n >> 1) + 1);
    return r;
  endfunction
endpackage

// File: rtl/rate_search.sv
module rate_search
  import spi_rate_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lim_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREQ_W-1:0] ref_hz,
  input  logic [FREQ_W-1:0] tgt_hz,
  output logic [IDX_W-1:0]  res_idx,
  output logic              done
);
  localparam int PROD_W = FREQ_W + RATIO_W;

  logic              busy_q;
  logic [IDX_W-1:0]  try_q;
  logic [IDX_W-1:0]  lim_q;
  logic [FREQ_W-1:0] ref_q;
  logic [FREQ_W-1:0] tgt_q;
  logic [PROD_W-1:0] prod;
  logic              hit;
  logic              last;

  assign req_ready = !busy_q;
  assign prod = PROD_W'(tgt_q) * PROD_W'(ratio_of(try_q));
  assign hit  = prod >= PROD_W'(ref_q);
  assign last = (try_q == lim_q - IDX_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      try_q   <= IDX_W'(IDX_SAFE);
      lim_q   <= IDX_W'(16);
      ref_q   <= '0;
      tgt_q   <= '0;
      res_idx <= IDX_W'(IDX_SAFE);
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          busy_q <= 1'b1;
          try_q  <= IDX_W'(IDX_SAFE);
          lim_q  <= lim_sel ? IDX_W'(IDX_TOP) : IDX_W'(16);
          ref_q  <= ref_hz;
          tgt_q  <= tgt_hz;
        end
      end else if (hit || last) begin
        busy_q  <= 1'b0;
        done    <= 1'b1;
        res_idx <= hit ? try_q : lim_q;
      end else begin
        try_q <= try_q + IDX_W'(1);
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_result_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_idx >= IDX_W'(IDX_SAFE) && res_idx <= IDX_W'(IDX_TOP)));
  assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res_idx));
endmodule

// File: rtl/rate_index_pick.sv
module rate_index_pick
  import spi_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_auto,
  input  logic             fast_ok,
  input  logic [IDX_W-1:0] man_idx,
  input  logic [IDX_W-1:0] auto_idx,
  output logic [IDX_W-1:0] use_idx
);
  logic [IDX_W-1:0] raw;

  always_comb begin
    raw = use_auto ? auto_idx : man_idx;
    if (raw == '0)
      use_idx = IDX_W'(IDX_SAFE);
    else if (raw == IDX_W'(1) && !fast_ok)
      use_idx = IDX_W'(IDX_SAFE);
    else if (raw > IDX_W'(IDX_TOP))
      use_idx = IDX_W'(IDX_TOP);
    else
      use_idx = raw;
  end

  assert_never_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (use_idx != '0) && (use_idx <= IDX_W'(IDX_TOP)));
  assert_fast_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (use_idx == IDX_W'(1)) |-> fast_ok);
endmodule

// File: rtl/sclk_shaper.sv
module sclk_shaper
  import spi_rate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               cpol,
  input  logic [RATIO_W-1:0] next_ratio,
  output logic               sclk,
  output logic               shift_stb,
  output logic               sample_stb
);
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] cur_ratio;
  logic [RATIO_W-1:0] half;
  logic               act_q;
  logic               wrap;

  assign half = cur_ratio >> 1;
  assign wrap = (cnt_q == cur_ratio - RATIO_W'(1));
  assign sclk = cpol ^ act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      cur_ratio  <= RATIO_W'(4);
      act_q      <= 1'b0;
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end else if (!en) begin
      cnt_q      <= '0;
      cur_ratio  <= next_ratio;
      act_q      <= 1'b0;
      shift_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      shift_stb  <= (cnt_q == '0);
      sample_stb <= (cnt_q == half);
      if (cnt_q == '0)
        act_q <= 1'b1;
      else if (cnt_q == half)
        act_q <= 1'b0;
      if (wrap) begin
        cnt_q     <= '0;
        cur_ratio <= next_ratio;
      end else begin
        cnt_q <= cnt_q + RATIO_W'(1);
      end
    end
  end

  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sclk == cpol && !shift_stb && !sample_stb));
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_stb && sample_stb));
  assert_ratio_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(cur_ratio));
  assert_shift_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> (sclk != cpol));
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_rate_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cpol,
  input  logic              fast_ok,
  input  logic              use_auto,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic              lim_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREQ_W-1:0] ref_hz,
  input  logic [FREQ_W-1:0] tgt_hz,
  output logic              sclk,
  output logic              shift_stb,
  output logic              sample_stb,
  output logic [IDX_W-1:0]  res_idx,
  output logic [WORD_W-1:0] res_word,
  output logic              done
);
  logic [IDX_W-1:0]   use_idx;
  logic [RATIO_W-1:0] next_ratio;

  rate_search #(.FREQ_W(FREQ_W)) u_search (
    .clk(clk), .rst_n(rst_n), .lim_sel(lim_sel),
    .req_valid(req_valid), .req_ready(req_ready),
    .ref_hz(ref_hz), .tgt_hz(tgt_hz),
    .res_idx(res_idx), .done(done)
  );

  rate_index_pick u_pick (
    .clk(clk), .rst_n(rst_n), .use_auto(use_auto), .fast_ok(fast_ok),
    .man_idx(idx_in), .auto_idx(res_idx), .use_idx(use_idx)
  );

  assign next_ratio = ratio_of(use_idx);

  sclk_shaper u_shape (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol),
    .next_ratio(next_ratio), .sclk(sclk),
    .shift_stb(shift_stb), .sample_stb(sample_stb)
  );

  always_comb begin
    res_word = '0;
    res_word[FIELD_LSB +: IDX_W] = res_idx;
  end
endmodule

// File: tb/spi_rate_gen_bench.sv
module spi_rate_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, cpol = 1'b0, fast_ok = 1'b0, use_auto = 1'b0, lim_sel = 1'b0;
  logic [4:0] idx_in = 5'd2;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] ref_hz = '0, tgt_hz = '0;
  logic sclk, shift_stb, sample_stb, done;
  logic [4:0] res_idx;
  logic [31:0] res_word;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  spi_rate_gen u_spi_rate_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .fast_ok(fast_ok),
    .use_auto(use_auto), .idx_in(idx_in), .lim_sel(lim_sel),
    .req_valid(req_valid), .req_ready(req_ready), .ref_hz(ref_hz), .tgt_hz(tgt_hz),
    .sclk(sclk), .shift_stb(shift_stb), .sample_stb(sample_stb),
    .res_idx(res_idx), .res_word(res_word), .done(done)
  );

  function automatic int tbl(int n);
    int t[19] = '{0, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192,
                  256, 384, 512, 768, 1024};
    return t[n];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_shift();
    int g = 0;
    @(negedge clk);
    while (!shift_stb && g < 5000) begin g++; @(negedge clk); end
  endtask

  // entered on a sample where shift_stb is expected; leaves on the next one
  task automatic measure(int ehi, int elo, string req);
    int hi = 0, lo = 0;
    chk(shift_stb == 1'b1, req, shift_stb, 1);
    while ((sclk ^ cpol) && hi < 5000) begin hi++; @(negedge clk); end
    chk(sample_stb == 1'b1, "R3", sample_stb, 1);
    while (!(sclk ^ cpol) && lo < 5000) begin lo++; @(negedge clk); end
    chk(hi == ehi, req, hi, ehi);
    chk(lo == elo, req, lo, elo);
  endtask

  task automatic run_idx(logic [4:0] n, int eff, string req);
    en = 1'b0; idx_in = n; tick(2);
    en = 1'b1;
    wait_shift();
    measure(tbl(eff) / 2, tbl(eff) - tbl(eff) / 2, req);
    en = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    chk(sclk == cpol, "R2", sclk, cpol);
    chk(!shift_stb && !sample_stb, "R2", shift_stb, 0);
    chk(req_ready == 1'b1, "R9", req_ready, 1);
    chk(res_idx == 5'd2, "R10", res_idx, 2);
    chk(res_word == 32'(2) << 14, "R10", res_word, 32'(2) << 14);
  endtask

  task automatic t_wave();
    fast_ok = 1'b1; run_idx(5'd1, 1, "R1");
    run_idx(5'd2, 2, "R1");
    run_idx(5'd3, 3, "R1");
    cpol = 1'b1; run_idx(5'd5, 5, "R1"); cpol = 1'b0;
    fast_ok = 1'b0;
  endtask

  task automatic t_sanitize();
    run_idx(5'd0, 2, "R4");
    run_idx(5'd1, 2, "R4");
    run_idx(5'd31, 18, "R4");
  endtask

  task automatic t_idle();
    int bad = 0;
    for (int p = 0; p < 2; p++) begin
      cpol = p[0]; en = 1'b0; tick(2);
      for (int i = 0; i < 8; i++) begin
        if (sclk != cpol || shift_stb || sample_stb) bad++;
        tick(1);
      end
      chk(bad == 0, "R2", bad, 0);
    end
    cpol = 1'b0;
  endtask

  task automatic t_change();
    en = 1'b0; idx_in = 5'd2; tick(2);
    en = 1'b1; wait_shift();
    idx_in = 5'd6;                 // asked mid-period: old ratio must finish
    measure(2, 2, "R5");
    measure(8, 8, "R5");
    en = 1'b0; tick(1);
  endtask

  task automatic search(int rf, int tg, bit sel, int eidx, string req);
    int k = 0, lat;
    lat = (eidx < (sel ? 18 : 16) || rf <= 0) ? eidx - 1 : (sel ? 16 : 14);
    lim_sel = sel; ref_hz = rf; tgt_hz = tg; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", req_ready, 0);
    while (!done && k < 100) begin k++; @(negedge clk); end
    chk(res_idx == eidx, req, res_idx, eidx);
    chk(k == lat, "R8", k, lat);
    chk(res_word == 32'(eidx) << 14, "R10", res_word, 32'(eidx) << 14);
    @(negedge clk);
    chk(!done && req_ready, "R8", done, 0);
  endtask

  task automatic t_search();
    search(100_000_000, 25_000_000, 1'b0, 2, "R6");
    search(100_000_000, 10_000_000, 1'b0, 5, "R6");
    search(100_000_000, 1_000_000, 1'b0, 12, "R6");
    search(48, 1, 1'b0, 9, "R6");
    search(-1, -1, 1'b0, 2, "R6");
    search(100_000_000, 100, 1'b0, 16, "R7");
    search(100_000_000, 100, 1'b1, 18, "R7");
    search(100_000_000, 100_000, 1'b1, 18, "R7");
  endtask

  task automatic t_backpressure();
    int k = 0;
    lim_sel = 1'b0; ref_hz = 100_000_000; tgt_hz = 100; req_valid = 1'b1;
    @(negedge clk);
    ref_hz = 100_000_000; tgt_hz = 25_000_000;   // held while busy
    while (!done && k < 100) begin
      if (req_ready) chk(1'b0, "R9", req_ready, 0);
      k++; @(negedge clk);
    end
    chk(res_idx == 5'd16, "R9", res_idx, 16);
    @(negedge clk);                               // second request taken here
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", req_ready, 0);
    @(negedge clk);
    chk(done && res_idx == 5'd2, "R9", res_idx, 2);
  endtask

  task automatic t_auto();
    search(100_000_000, 10_000_000, 1'b0, 5, "R11");
    idx_in = 5'd2; use_auto = 1'b1; en = 1'b0; tick(2);
    en = 1'b1; wait_shift();
    measure(6, 6, "R11");
    en = 1'b0; use_auto = 1'b0; tick(1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_wave();
    t_sanitize();
    t_idle();
    t_change();
    t_search();
    t_backpressure();
    t_auto();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule